// File: doc/BRIEF.md
# Chunk-Aligned Stream Flow Arbiter

This block merges several AXI4-Stream sources onto a single output stream. Every source carries its own flow identity (a 6-bit TID and a 10-bit TDEST). The data, byte-keep, end-of-packet, TID and TDEST fields of the granted source reach the output unchanged. TSTRB and TUSER are not carried. Backpressure from the output reaches only the source that holds the grant.

The arbiter may hand the output to another flow only at a switch point. A switch point is an accepted beat that either completes a whole multiple of 64 bytes since the flow was granted, or carries TLAST. This keeps the downstream packetizer working on aligned chunks. Each accepted beat adds the full beat width in bytes to a per-grant byte count, whatever its keep bits say. The beat width is a parameter from 128 to 512 bits.

The control is a two-state machine. `ST_ARB` offers nothing on the output and gives TREADY to no source. In the first cycle in which any source asserts TVALID, it takes transition `T_GRANT`: it latches a round-robin choice and moves to `ST_XFER`. In `ST_XFER` the granted source is connected to the output. An accepted switch-point beat takes transition `T_RELEASE` back to `ST_ARB`. Any other cycle stays in `ST_XFER`.

Top module: `axis_flow_arbiter`

## Requirements
- R1: While reset is asserted, m_tvalid is 0 and every bit of s_tready is 0, even with all sources valid and m_tready high.
- R2: Source i occupies bits [i*DATA_W +: DATA_W] of s_tdata, [i*DATA_W/8 +: DATA_W/8] of s_tkeep, [i*6 +: 6] of s_tid and [i*10 +: 10] of s_tdest. Each accepted output beat presents the granted source's TDATA, TKEEP, TLAST, TID and TDEST unchanged, and each source's beats leave in the order they were offered.
- R3: Every accepted beat adds DATA_W/8 bytes to the count for the current grant. The grant may move only after an accepted beat that either brings this count to a multiple of 64 or carries TLAST. Otherwise the next accepted beat comes from the same source.
- R4: After a switch point, the next grant goes to the first source with TVALID high, searching upward in index from the last granted source and wrapping around. The last granted source is considered last, so a sole requester keeps the grant. After reset the search starts at source 0.
- R5: Only the granted source sees TREADY, and it sees the value of m_tready. Every other source sees 0. When the granted source is valid, m_tvalid is high.
- R6: While m_tvalid is high and m_tready is low, the grant does not change, so the same flow is still presented in the next cycle.
- R7: The cycle after a switch-point beat is accepted, and every following cycle until some source is valid, has m_tvalid at 0 and s_tready all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | N_SRC | Per-source valid |
| s_tready | output | N_SRC | Per-source ready |
| s_tdata | input | N_SRC*DATA_W | Packed source data |
| s_tkeep | input | N_SRC*DATA_W/8 | Packed source byte-keep |
| s_tlast | input | N_SRC | Per-source end of packet |
| s_tid | input | N_SRC*6 | Packed source flow IDs |
| s_tdest | input | N_SRC*10 | Packed source destinations |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready |
| m_tdata | output | DATA_W | Output data |
| m_tkeep | output | DATA_W/8 | Output byte-keep |
| m_tlast | output | 1 | Output end of packet |
| m_tid | output | 6 | Output flow ID |
| m_tdest | output | 10 | Output destination |

## Verification
The hardest case to reach from the ports is a switch point that falls in the middle of a packet while other sources are competing. The round-robin choice then has to skip sources that are momentarily idle, and the output must also be stalled at that moment. The bench sweeps packet lengths of 1 to 9 beats against a 16-byte beat, so chunk boundaries land before, on and after TLAST. Each source's valid gating is offset by a different phase, and in alternate runs the output ready follows an irregular pattern. The bench models the expected grant from the valid vector it drives in each arbitration cycle.

// File: rtl/axis_flow_arbiter_pkg.sv
package axis_flow_arbiter_pkg;
    typedef enum logic [0:0] {
        ST_ARB  = 1'b0,
        ST_XFER = 1'b1
    } arb_state_e;
endpackage

// File: rtl/axis_rr_picker.sv
module axis_rr_picker #(
    parameter int N_SRC = 4,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] req,
    input  logic [IDX_W-1:0] last,
    output logic [IDX_W-1:0] pick,
    output logic             any
);
    always_comb begin
        pick = last;
        any  = |req;
        // Descending search so the nearest requester after 'last' wins.
        for (int k = N_SRC; k >= 1; k--) begin
            int idx;
            idx = (int'(last) + k) % N_SRC;
            if (req[idx]) pick = IDX_W'(idx);
        end
    end
endmodule

// File: rtl/axis_chunk_counter.sv
module axis_chunk_counter #(
    parameter int BEAT_BYTES  = 16,
    parameter int CHUNK_BYTES = 64,
    localparam int CNT_W = $clog2(CHUNK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_boundary
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(BEAT_BYTES % CHUNK_BYTES);

    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        cnt_next    = cnt_q + STEP;
        at_boundary = (cnt_next == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (advance)    cnt_q <= cnt_next;
    end
endmodule

// File: rtl/axis_flow_arbiter.sv
module axis_flow_arbiter
    import axis_flow_arbiter_pkg::*;
#(
    parameter int N_SRC       = 4,
    parameter int DATA_W      = 128,
    parameter int ID_W        = 6,
    parameter int DEST_W      = 10,
    parameter int CHUNK_BYTES = 64,
    localparam int KEEP_W     = DATA_W / 8,
    localparam int IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CNT_W      = $clog2(CHUNK_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SRC-1:0]         s_tvalid,
    output logic [N_SRC-1:0]         s_tready,
    input  logic [N_SRC*DATA_W-1:0]  s_tdata,
    input  logic [N_SRC*KEEP_W-1:0]  s_tkeep,
    input  logic [N_SRC-1:0]         s_tlast,
    input  logic [N_SRC*ID_W-1:0]    s_tid,
    input  logic [N_SRC*DEST_W-1:0]  s_tdest,
    output logic                     m_tvalid,
    input  logic                     m_tready,
    output logic [DATA_W-1:0]        m_tdata,
    output logic [KEEP_W-1:0]        m_tkeep,
    output logic                     m_tlast,
    output logic [ID_W-1:0]          m_tid,
    output logic [DEST_W-1:0]        m_tdest
);
    initial begin
        assert (DATA_W >= 128 && DATA_W <= 512 && DATA_W % 8 == 0)
            else $error("DATA_W must be 128..512");
    end

    arb_state_e       state_q;
    arb_state_e       state_d;
    logic [IDX_W-1:0] grant_q;
    logic [IDX_W-1:0] pick;
    logic             any_req;
    logic             accept;
    logic             release_pt;
    logic             at_boundary;
    logic [CNT_W-1:0] cnt_q;

    axis_rr_picker #(.N_SRC(N_SRC)) u_picker (
        .req  (s_tvalid),
        .last (grant_q),
        .pick (pick),
        .any  (any_req)
    );

    axis_chunk_counter #(
        .BEAT_BYTES  (KEEP_W),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (state_q == ST_ARB || release_pt),
        .advance     (accept),
        .cnt_q       (cnt_q),
        .at_boundary (at_boundary)
    );

    // Next-state and release decision
    always_comb begin
        accept     = m_tvalid && m_tready;
        release_pt = accept && (m_tlast || at_boundary);
        state_d    = state_q;
        unique case (state_q)
            ST_ARB:  if (any_req)    state_d = ST_XFER;  // T_GRANT
            ST_XFER: if (release_pt) state_d = ST_ARB;   // T_RELEASE
            default: state_d = ST_ARB;
        endcase
    end

    // State and grant register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARB;
            grant_q <= IDX_W'(N_SRC - 1);
        end else begin
            state_q <= state_d;
            if (state_q == ST_ARB && any_req) grant_q <= pick;
        end
    end

    // Outputs: path from the granted source
    always_comb begin
        m_tdata  = s_tdata[grant_q*DATA_W +: DATA_W];
        m_tkeep  = s_tkeep[grant_q*KEEP_W +: KEEP_W];
        m_tlast  = s_tlast[grant_q];
        m_tid    = s_tid[grant_q*ID_W +: ID_W];
        m_tdest  = s_tdest[grant_q*DEST_W +: DEST_W];
        m_tvalid = 1'b0;
        s_tready = '0;
        unique case (state_q)
            ST_ARB: ;
            ST_XFER: begin
                m_tvalid          = s_tvalid[grant_q];
                s_tready[grant_q] = m_tready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/axis_flow_arbiter_checker.sv
module axis_flow_arbiter_checker
    import axis_flow_arbiter_pkg::*;
#(
    parameter int N_SRC       = 4,
    parameter int DATA_W      = 128,
    parameter int CHUNK_BYTES = 64,
    localparam int IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int BEATS_PER  = (CHUNK_BYTES * 8 >= DATA_W) ? (CHUNK_BYTES * 8 / DATA_W) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] s_tready,
    input logic             m_tvalid,
    input logic             m_tready,
    input logic             m_tlast,
    input arb_state_e       state_q,
    input logic [IDX_W-1:0] grant_q
);
    int beats_seen;

    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_ARB) beats_seen <= 0;
        else if (m_tvalid && m_tready)   beats_seen <= (beats_seen + 1) % BEATS_PER;
    end

    p_ready_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_tready));

    p_ready_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tready & ~(N_SRC'(1) << grant_q)) == '0);

    p_grant_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> $stable(grant_q) && m_tvalid);

    p_switch_via_arb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q != $past(grant_q)) |-> ($past(state_q) == ST_ARB));

    p_no_early_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && m_tvalid && m_tready && !m_tlast && beats_seen + 1 != BEATS_PER)
        |=> (state_q == ST_XFER && $stable(grant_q)));
endmodule

bind axis_flow_arbiter axis_flow_arbiter_checker #(
    .N_SRC       (N_SRC),
    .DATA_W      (DATA_W),
    .CHUNK_BYTES (CHUNK_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tready (s_tready),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tlast  (m_tlast),
    .state_q  (state_q),
    .grant_q  (grant_q)
);

// File: tb/axis_flow_arbiter_bench.sv
module axis_flow_arbiter_bench;
    localparam int N    = 4;
    localparam int DW   = 128;
    localparam int KW   = DW / 8;
    localparam int IW   = 6;
    localparam int DSW  = 10;
    localparam int CHUNK = 64;
    localparam int PKTS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]     s_tvalid = '0;
    logic [N-1:0]     s_tready;
    logic [N*DW-1:0]  s_tdata = '0;
    logic [N*KW-1:0]  s_tkeep = '0;
    logic [N-1:0]     s_tlast = '0;
    logic [N*IW-1:0]  s_tid = '0;
    logic [N*DSW-1:0] s_tdest = '0;
    logic             m_tvalid;
    logic             m_tready = 1'b0;
    logic [DW-1:0]    m_tdata;
    logic [KW-1:0]    m_tkeep;
    logic             m_tlast;
    logic [IW-1:0]    m_tid;
    logic [DSW-1:0]   m_tdest;

    axis_flow_arbiter #(.N_SRC(N), .DATA_W(DW)) u_axis_flow_arbiter (
        .clk(clk), .rst_n(rst_n),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .s_tkeep(s_tkeep), .s_tlast(s_tlast), .s_tid(s_tid), .s_tdest(s_tdest),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tid(m_tid), .m_tdest(m_tdest)
    );

    int checks = 0;
    int errors = 0;
    int total_cyc = 0;
    bit wd_hit = 0;

    int len [N];
    int pos [N];
    int done_pk [N];
    int seq [N];
    int rx_seq [N];
    bit vld [N];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit vgate(int cyc, int i, int s);
        if (s % 3 == 0) return 1'b1;
        return ((cyc + i * 3 + s) % 4) != 0;
    endfunction

    function automatic bit rgate(int cyc, int s);
        if (s % 2 == 0) return 1'b1;
        return ((cyc * 7 + s) % 5) > 1;
    endfunction

    function automatic int rr_next(logic [N-1:0] v, int last);
        for (int k = 1; k <= N; k++) begin
            if (v[(last + k) % N]) return (last + k) % N;
        end
        return -1;
    endfunction

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            s_tvalid[i] = vld[i];
            s_tdata[i*DW +: DW] = DW'({8'(i), 24'(seq[i])});
            s_tlast[i] = (pos[i] == len[i] - 1);
            s_tkeep[i*KW +: KW] = (pos[i] == len[i] - 1) ? KW'(16'h00FF) : {KW{1'b1}};
            s_tid[i*IW +: IW] = IW'(i * 3 + 1);
            s_tdest[i*DSW +: DSW] = DSW'(200 + i);
        end
    endtask

    task automatic run_scenario(input int s);
        int cyc, last, eg, bytes, k;
        bit pending, fresh, prev_stall, finished;
        logic [IW-1:0] stall_tid;
        logic [N-1:0] accv;
        for (int i = 0; i < N; i++) begin
            len[i] = 1 + ((s * 3 + i * 5) % 9);
            pos[i] = 0; done_pk[i] = 0; seq[i] = 0; rx_seq[i] = 0; vld[i] = 1'b1;
        end
        rst_n = 1'b0;
        m_tready = 1'b1;
        drive();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!m_tvalid && s_tready == '0, "R1", "reset quiet", {s_tready, m_tvalid}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        cyc = 0; last = N - 1; eg = -1; bytes = 0;
        pending = 1'b1; fresh = 1'b0; prev_stall = 1'b0; stall_tid = '0; finished = 1'b0;
        while (!finished && !wd_hit) begin
            @(negedge clk);
            accv = s_tvalid & s_tready;
            if (pending) begin
                check(!m_tvalid && s_tready == '0, "R7", "arbitration bubble",
                      {s_tready, m_tvalid}, 0);
                if (|s_tvalid) begin
                    eg = rr_next(s_tvalid, last);
                    pending = 1'b0;
                    fresh = 1'b1;
                end
            end else begin
                check((s_tready & ~(N'(1) << eg)) == '0, "R5", "ready outside grant", s_tready, N'(1) << eg);
                if (vld[eg]) check(m_tvalid && s_tready[eg] == m_tready, "R5", "granted ready/valid",
                                   {s_tready[eg], m_tvalid}, {m_tready, 1'b1});
                if (prev_stall) check(m_tvalid && m_tid == stall_tid, "R6", "stalled flow held", m_tid, stall_tid);
                if (m_tvalid && m_tready) begin
                    k = int'(m_tdata[31:24]);
                    check(k == eg, fresh ? "R4" : "R3", "beat source", k, eg);
                    if (k < N) begin
                        check(m_tdata[23:0] == 24'(rx_seq[k]) && m_tid == IW'(k * 3 + 1)
                              && m_tdest == DSW'(200 + k) && m_tlast == (pos[k] == len[k] - 1)
                              && m_tkeep == ((pos[k] == len[k] - 1) ? KW'(16'h00FF) : {KW{1'b1}}),
                              "R2", "passthrough seq", m_tdata[23:0], rx_seq[k]);
                        rx_seq[k]++;
                    end
                    fresh = 1'b0;
                    bytes += KW;
                    if (bytes % CHUNK == 0 || m_tlast) begin
                        pending = 1'b1; last = eg; bytes = 0;
                    end
                end
            end
            prev_stall = m_tvalid && !m_tready;
            stall_tid = m_tid;
            @(posedge clk); #1;
            cyc++; total_cyc++;
            if (total_cyc > 150000) wd_hit = 1'b1;
            for (int i = 0; i < N; i++) begin
                if (accv[i]) begin
                    seq[i]++; pos[i]++; vld[i] = 1'b0;
                    if (pos[i] == len[i]) begin pos[i] = 0; done_pk[i]++; end
                end
                if (!vld[i]) vld[i] = (done_pk[i] < PKTS) && vgate(cyc, i, s);
            end
            m_tready = rgate(cyc, s);
            drive();
            finished = pending;
            for (int i = 0; i < N; i++) if (done_pk[i] < PKTS) finished = 1'b0;
        end
        for (int i = 0; i < N; i++)
            check(rx_seq[i] == PKTS * len[i], "R2", "beats delivered", rx_seq[i], PKTS * len[i]);
    endtask

    initial begin
        for (int s = 0; s < 6 && !wd_hit; s++) run_scenario(s);
        if (wd_hit) begin
            checks++; errors++;
            $display("FAIL R3 watchdog: actual %0d expected %0d", total_cyc, 150000);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule